// File: doc/BRIEF.md
# Error Address Capture Register File

This block is a small register slice that sits on the error-logging path of a RAM controller. The memory interface raises a one-cycle error strobe and presents the failing access's double-word address. The block then latches that 64-bit-aligned offset, measured from the base of the protected memory, and holds it for software. After a capture the register is locked. Software re-arms it by reading it. The read leaves the value in place, so the old address stays visible until a later error replaces it. Errors that arrive while the register is locked are dropped.

A second register holds test stimulus for the redundant address-decode checking logic: a chip-select pattern and a single ECC-select bit. Both drive output pins directly. Only privileged bus writes may change this register.

The bus side is a plain single-cycle port: select, write enable, privilege qualifier, byte offset and 32-bit data. Read data is combinational in the cycle the select is high. There is no valid/ready handshake. The port never stalls and accepts every access in the cycle it is presented, so back-pressure does not arise. The error strobe is likewise taken in the cycle it is asserted.

Top module: `errcap_regs`

## Requirements
- R1: A read at offset 0x3C returns the captured double-word address in bits 22:3 (access address bit n in bit n); bits 31:23 and 2:0 read as zero.
- R2: The capture path is armed after reset, so the first error strobe after reset is recorded.
- R3: Once an address has been captured, further error strobes leave the register unchanged until software reads offset 0x3C.
- R4: A read of offset 0x3C does not alter the stored address. It re-arms capture, so the next error strobe overwrites the value.
- R5: If an error strobe and a read of offset 0x3C occur in the same cycle, the read returns the old value, the new error is dropped, and capture is re-armed for later errors.
- R6: Bus writes to offset 0x3C, privileged or not, change neither the stored address nor the armed state.
- R7: The test vector register at offset 0x38 resets to zero, and both stimulus outputs are zero after reset.
- R8: A privileged write to offset 0x38 loads bits 15:0 into the chip-select stimulus and bit 26 into the ECC-select stimulus. A read of 0x38 returns those fields in the same positions, with every other bit zero, whatever was written there.
- R9: An unprivileged write to offset 0x38 is ignored without error, and the register and stimulus outputs keep their values.
- R10: A read at any word offset other than 0x38 and 0x3C returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_off | input | OFS_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_we is low |
| err_strobe | input | 1 | Error detected on the access in this cycle |
| err_dw_addr | input | ADDR_W-3 (20) | Failing access address, bits 22:3 |
| stim_cs | output | CS_W (16) | Chip-select stimulus for decode checking |
| stim_ecc | output | 1 | ECC-select stimulus for decode checking |

## Verification
The clocked properties assume the following:
- Reset is applied before the first access.
- bus_sel, bus_we, bus_priv and bus_off are known values at every active edge.
- The error strobe is a clean level sampled at the edge, so every cycle in which it is high counts as one error.

The bench drives all inputs on the falling edge and holds each access for exactly one rising edge, with an idle cycle between accesses. It raises the strobe and a read together only in the deliberate same-cycle case, so the ordering in R5 is exercised alone and in a known state.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int REG_W       = 32;
  localparam int DW_LSB      = 3;
  localparam int ECC_POS     = 26;
  localparam logic [7:0] OFF_TESTVEC = 8'h38;
  localparam logic [7:0] OFF_CAPTURE = 8'h3C;
endpackage

// File: rtl/errcap_capture.sv
module errcap_capture #(
  parameter int DW_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_strobe,
  input  logic [DW_W-1:0] err_dw_addr,
  input  logic            cap_read,
  output logic [DW_W-1:0] cap_dw,
  output logic            cap_armed
);
  logic [DW_W-1:0] addr_q;
  logic            armed_q;
  logic            take;

  // A read in the same cycle wins: the strobe is dropped and capture re-arms.
  assign take = err_strobe && armed_q && !cap_read;

  // The stored address has no defined reset value.
  always_ff @(posedge clk) begin
    if (take) addr_q <= err_dw_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (cap_read) armed_q <= 1'b1;
    else if (take)     armed_q <= 1'b0;
  end

  assign cap_dw    = addr_q;
  assign cap_armed = armed_q;

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q) |=> $stable(addr_q));
  p_first_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe && armed_q && !cap_read) |=> (!armed_q && addr_q == $past(err_dw_addr)));
  p_read_rearms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_read |=> armed_q);
  p_same_cycle_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_read && err_strobe) |=> $stable(addr_q));
endmodule

// File: rtl/errcap_testvec.sv
module errcap_testvec
  import errcap_pkg::*;
#(
  parameter int CS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tv_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [CS_W-1:0]  stim_cs,
  output logic             stim_ecc
);
  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << ECC_POS) | ((REG_W'(1) << CS_W) - REG_W'(1));

  logic [CS_W-1:0] cs_q;
  logic            ecc_q;
  logic            resv_touch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '0;
      ecc_q <= 1'b0;
    end else if (tv_wr) begin
      cs_q  <= wdata[CS_W-1:0];
      ecc_q <= wdata[ECC_POS];
    end
  end

  assign stim_cs  = cs_q;
  assign stim_ecc = ecc_q;

  assign resv_touch = |(wdata & ~KEEP_MASK);

  p_fields_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tv_wr && resv_touch) |=> (stim_cs == $past(wdata[CS_W-1:0]) && stim_ecc == $past(wdata[ECC_POS])));
  p_hold_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tv_wr) |=> ($stable(cs_q) && $stable(ecc_q)));
endmodule

// File: rtl/errcap_rdmux.sv
module errcap_rdmux
  import errcap_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int ADDR_W = 23,
  parameter int CS_W   = 16,
  localparam int DW_W  = ADDR_W - DW_LSB
) (
  input  logic             rd_en,
  input  logic [OFS_W-1:0] off,
  input  logic [DW_W-1:0]  cap_dw,
  input  logic [CS_W-1:0]  cs,
  input  logic             ecc,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] cap_word;
  logic [REG_W-1:0] tv_word;

  always_comb begin
    cap_word = '0;
    cap_word[ADDR_W-1:DW_LSB] = cap_dw;
    tv_word = '0;
    tv_word[CS_W-1:0] = cs;
    tv_word[ECC_POS]  = ecc;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (off == OFS_W'(OFF_CAPTURE))      rdata = cap_word;
      else if (off == OFS_W'(OFF_TESTVEC)) rdata = tv_word;
    end
  end
endmodule

// File: rtl/errcap_regs.sv
module errcap_regs
  import errcap_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int ADDR_W = 23,
  parameter int CS_W   = 16,
  localparam int DW_W  = ADDR_W - DW_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_priv,
  input  logic [OFS_W-1:0] bus_off,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             err_strobe,
  input  logic [DW_W-1:0]  err_dw_addr,
  output logic [CS_W-1:0]  stim_cs,
  output logic             stim_ecc
);
  logic            rd_en;
  logic            cap_read;
  logic            tv_wr;
  logic [DW_W-1:0] cap_dw;
  logic            cap_armed;

  assign rd_en    = bus_sel && !bus_we;
  assign cap_read = rd_en && (bus_off == OFS_W'(OFF_CAPTURE));
  assign tv_wr    = bus_sel && bus_we && bus_priv && (bus_off == OFS_W'(OFF_TESTVEC));

  errcap_capture #(.DW_W(DW_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_strobe (err_strobe),
    .err_dw_addr(err_dw_addr),
    .cap_read   (cap_read),
    .cap_dw     (cap_dw),
    .cap_armed  (cap_armed)
  );

  errcap_testvec #(.CS_W(CS_W)) u_testvec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tv_wr   (tv_wr),
    .wdata   (bus_wdata),
    .stim_cs (stim_cs),
    .stim_ecc(stim_ecc)
  );

  errcap_rdmux #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .CS_W(CS_W)) u_rdmux (
    .rd_en (rd_en),
    .off   (bus_off),
    .cap_dw(cap_dw),
    .cs    (stim_cs),
    .ecc   (stim_ecc),
    .rdata (bus_rdata)
  );

  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_read |-> (bus_rdata[REG_W-1:ADDR_W] == '0 && bus_rdata[DW_LSB-1:0] == '0));
  p_cap_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !err_strobe) |=> ($stable(cap_dw) && cap_armed == $past(cap_armed)));
  p_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_off != OFS_W'(OFF_CAPTURE) && bus_off != OFS_W'(OFF_TESTVEC)) |-> bus_rdata == '0);
  p_tv_reset_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (stim_cs == '0 && !stim_ecc));
endmodule

// File: tb/errcap_regs_test.sv
`timescale 1ns/1ps
module errcap_regs_test;
  localparam int DW_W = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_priv = 1'b0;
  logic [7:0]  bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        err_strobe = 1'b0;
  logic [DW_W-1:0] err_dw_addr = '0;
  logic [15:0] stim_cs;
  logic        stim_ecc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  errcap_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_priv(bus_priv),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_strobe(err_strobe), .err_dw_addr(err_dw_addr),
    .stim_cs(stim_cs), .stim_ecc(stim_ecc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_off = off;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] off, input logic [31:0] d, input logic priv);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_priv = priv; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic raise_err(input logic [DW_W-1:0] a);
    @(negedge clk);
    err_strobe = 1'b1; err_dw_addr = a;
    @(negedge clk);
    err_strobe = 1'b0;
  endtask

  task automatic read_with_err(input logic [DW_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    err_strobe = 1'b1; err_dw_addr = a;
    bus_sel = 1'b1; bus_we = 1'b0; bus_off = 8'h3C;
    #1 d = bus_rdata;
    @(negedge clk);
    err_strobe = 1'b0; bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] cap_word(input logic [DW_W-1:0] a);
    return {9'd0, a, 3'd0};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [DW_W-1:0] a, b;
    logic [31:0] tv_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state of the test vector
    bus_read(8'h38, d);
    check("R7 testvec reset", d, 32'h0);
    check("R7 stim reset", {15'd0, stim_ecc, stim_cs}, 32'h0);

    // R2 / R1: first error after reset is captured
    raise_err(20'hABCDE);
    bus_read(8'h3C, d);
    check("R2 R1 first capture", d, cap_word(20'hABCDE));

    // R3 / R4 sweep over address patterns
    for (int i = 0; i < 40; i++) begin
      if (i == 0) a = '0;
      else if (i == 1) a = '1;
      else a = DW_W'(i * 32'h3A5C7 + 32'h1F);
      b = ~a;
      raise_err(a);
      raise_err(b);
      bus_read(8'h3C, d);
      check("R3 locked after capture", d, cap_word(a));
      bus_read(8'h3C, d);
      check("R4 read keeps value", d, cap_word(a));
      raise_err(b);
      bus_read(8'h3C, d);
      check("R4 rearmed overwrite", d, cap_word(b));
    end

    // R6: writes to the capture register do nothing
    raise_err(20'h12345);
    bus_write(8'h3C, 32'hFFFF_FFFF, 1'b1);
    bus_write(8'h3C, 32'h0000_0000, 1'b0);
    raise_err(20'h54321);
    bus_read(8'h3C, d);
    check("R6 write inert, still locked", d, cap_word(20'h12345));
    bus_write(8'h3C, 32'h0000_0000, 1'b1);
    raise_err(20'h0F0F0);
    bus_read(8'h3C, d);
    check("R6 write did not lock", d, cap_word(20'h0F0F0));

    // R5: same-cycle error and read
    raise_err(20'h11111);
    read_with_err(20'h22222, d);
    check("R5 read returns old", d, cap_word(20'h11111));
    bus_read(8'h3C, d);
    check("R5 error dropped", d, cap_word(20'h11111));
    raise_err(20'h33333);
    bus_read(8'h3C, d);
    check("R5 rearmed", d, cap_word(20'h33333));
    // same-cycle while armed: also dropped
    read_with_err(20'h44444, d);
    bus_read(8'h3C, d);
    check("R5 armed same-cycle dropped", d, cap_word(20'h33333));

    // R8 sweep of test vector writes with reserved bits toggled
    tv_exp = '0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = (i * 32'h9E37_79B9) ^ 32'hA5A5_0000;
      bus_write(8'h38, w, 1'b1);
      tv_exp = w & 32'h0400_FFFF;
      bus_read(8'h38, d);
      check("R8 testvec readback", d, tv_exp);
      check("R8 stim outputs", {5'd0, stim_ecc, 10'd0, stim_cs}, tv_exp);
    end

    // R9: unprivileged write ignored
    bus_write(8'h38, ~tv_exp, 1'b0);
    bus_read(8'h38, d);
    check("R9 unpriv write ignored", d, tv_exp);
    check("R9 stim unchanged", {5'd0, stim_ecc, 10'd0, stim_cs}, tv_exp);

    // R10: other offsets read zero
    for (int o = 0; o < 256; o += 4) begin
      if (o != 8'h38 && o != 8'h3C) begin
        bus_read(8'(o), d);
        check("R10 unmapped read", d, 32'h0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule